// File: doc/BRIEF.md
# Channel Output Gating and Fault Diagnosis

This block is the digital core of a multichannel protected power switch. For every channel it merges a parallel control pin with a serially programmed on bit, and the merge is either an OR or an AND. It then applies a global enable and the chip reset, and masks the result with a per-channel overtemperature shutdown. That shutdown either restarts by itself or stays latched until the channel is commanded again. The resulting drive enables go to the analog output stages.

The analog detectors sit outside the block. They report raw overload, channel overtemperature, open-load and bypassed-switch conditions. The block qualifies each report with a filter counted in microsecond ticks and keeps a 2-bit diagnosis code per channel until software clears the codes. It drives a live diagnostic pin per channel and an open-drain style general fault flag. The last diagnostic pin can instead serve as a combined overtemperature flag. For the last few channels, a configuration bit can disable off-state detection.

Top module: `chan_guard_diag`

## Requirements
- R1: Each channel's request is `par_in[i] | spi_on[i]` when `and_sel` is 0 and `par_in[i] & spi_on[i]` when `and_sel` is 1.
- R2: While `gate_en` is low every `drv_on` bit is 0. While `rst_n` is low every `drv_on` bit is 0, every diagnosis code returns to 11, and all latches and flags clear.
- R3: With `latch_sel` = 0, a commanded channel whose `raw_ot` is high has `drv_on` low in the same cycle, and drives again as soon as `raw_ot` falls while the request is still high.
- R4: With `latch_sel` = 1, overtemperature on a commanded channel keeps it off after `raw_ot` falls. A new rising edge of the request releases it, and the output returns one cycle after that edge.
- R5: A raw fault becomes a filtered fault only after the same fault class is present for `FILT_TICKS` ticks of `tick_us`. If the fault drops or changes class before then, the count restarts from zero.
- R6: Each channel's code sits in `diag_code[2i+1:2i]`: 11 means normal, 10 means overload or overtemperature while commanded on, 01 means open load while commanded off, and 00 means bypassed switch while commanded off. Bypass wins over open load, and a newer filtered fault overwrites the code.
- R7: A `diag_clr` pulse sets every code to 11 and restarts every filter count. It leaves the channel overtemperature flags unchanged.
- R8: `fault_n` is low exactly when at least one code differs from 11.
- R9: `diag_pin[i]` equals the channel's request, and is inverted while a filtered fault is present. It does not latch.
- R10: A filtered overtemperature on a commanded channel sets that channel's flag. The flag clears only on a rising edge of that channel's request. `chan_ot` is the OR of all the flags. With `ot_pin_sel` = 1 the last diagnostic pin is low while any flag or `ic_hot` is high.
- R11: For the upper `NCFG` channels, `sense_off[j]` = 1 (for channel `NCH-NCFG+j`) makes open-load and bypass reports have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces outputs off |
| tick_us | input | 1 | One-cycle pulse per microsecond, filter timebase |
| gate_en | input | 1 | Global enable, low forces all outputs off |
| par_in | input | NCH | Parallel channel controls, active high |
| spi_on | input | NCH | Serially programmed on bits, active high |
| and_sel | input | 1 | 0: OR combine, 1: AND combine |
| latch_sel | input | 1 | 0: auto restart, 1: latching overtemperature shutdown |
| ot_pin_sel | input | 1 | 1: last diagnostic pin acts as overtemperature flag |
| sense_off | input | NCFG | Off-state detection disable for the upper channels |
| raw_ovl | input | NCH | Raw overload reports |
| raw_ot | input | NCH | Raw channel overtemperature reports |
| raw_ol | input | NCH | Raw open-load reports |
| raw_byp | input | NCH | Raw bypassed-switch reports |
| ic_hot | input | 1 | Die overtemperature, non-latching |
| diag_clr | input | 1 | Clears the diagnosis codes |
| drv_on | output | NCH | Drive enable per channel |
| diag_pin | output | NCH | Live diagnostic pins |
| diag_code | output | 2*NCH | Latched 2-bit codes, channel i at bits 2i+1:2i |
| chan_ot | output | 1 | OR of the channel overtemperature flags |
| fault_n | output | 1 | Low while any code is not normal |

## Verification
The bench drives a fault that drops after half the filter time and expects no code and no pin inversion. It also switches a fault from open load to bypass mid-stream and expects the count to restart, so a design that kept counting across classes would latch a bypass code early. In latching mode it releases `raw_ot` without a new request edge, where a restart-style design would wrongly drive again. It also checks that a code clear leaves the overtemperature flag set, and that a disabled upper channel ignores a long open-load report. A design that shared one flag clear with the code clear, or masked the wrong channel index, shows a mismatch on those cycles.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
   typedef logic [1:0] dcode_t;
   localparam dcode_t DC_NORMAL = 2'b11;
   localparam dcode_t DC_ONSTATE = 2'b10;
   localparam dcode_t DC_OPEN = 2'b01;
   localparam dcode_t DC_BYPASS = 2'b00;
endpackage

// File: rtl/cgd_gate.sv
module cgd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic par,
   input  logic spi,
   input  logic and_sel,
   input  logic gate_en,
   input  logic latch_sel,
   input  logic raw_ot,
   output logic req,
   output logic cmd,
   output logic rise,
   output logic drv_on
);
   logic req_q;
   logic ot_lock;
   logic ot_lock_d;

   always_comb begin
      req  = and_sel ? (par & spi) : (par | spi);
      cmd  = req & gate_en;
      rise = req & ~req_q;
      ot_lock_d = latch_sel & ((ot_lock & ~rise) | (cmd & raw_ot));
      drv_on = rst_n & cmd & ~raw_ot & ~ot_lock;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         ot_lock <= 1'b0;
      end else begin
         req_q   <= req;
         ot_lock <= ot_lock_d;
      end
   end

   // R3: restart mode drives again once the sensor is quiet
   p_restart_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_sel && $past(!latch_sel) && cmd && !raw_ot) |-> drv_on);

   // R4: latched shutdown holds until a new request edge
   p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_sel && $past(latch_sel) && $past(cmd && raw_ot) && !rise) |-> !drv_on);
endmodule

// File: rtl/cgd_filter.sv
module cgd_filter #(
   parameter int FILT_TICKS = 100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clr,
   input  logic            raw_any,
   input  cgd_pkg::dcode_t rcode,
   output logic            filt,
   output cgd_pkg::dcode_t code
);
   import cgd_pkg::*;
   localparam int CNT_W = $clog2(FILT_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_TICKS);

   logic [CNT_W-1:0] cnt;
   dcode_t kind_q;
   logic same_kind;

   generate
      if (FILT_TICKS < 1) begin : g_bad_filt
         $error("cgd_filter: FILT_TICKS must be at least 1");
      end
   endgenerate

   always_comb begin
      same_kind = raw_any & (rcode == kind_q);
      filt      = same_kind & (cnt == CNT_TOP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         kind_q <= DC_NORMAL;
         code   <= DC_NORMAL;
      end else begin
         kind_q <= rcode;
         if (clr || !same_kind) cnt <= '0;
         else if (tick && cnt != CNT_TOP) cnt <= cnt + 1'b1;
         if (clr) code <= DC_NORMAL;
         else if (filt) code <= rcode;
      end
   end

   // R5: a code only moves after a full filter window
   p_code_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(code) && !$past(clr)) |-> ($past(cnt) == CNT_TOP));

   // R7: clear returns the code to normal
   p_clear_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (code == DC_NORMAL));
endmodule

// File: rtl/chan_guard_diag.sv
module chan_guard_diag #(
   parameter int NCH        = 6,
   parameter int NCFG       = 3,
   parameter int FILT_TICKS = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_us,
   input  logic              gate_en,
   input  logic [NCH-1:0]    par_in,
   input  logic [NCH-1:0]    spi_on,
   input  logic              and_sel,
   input  logic              latch_sel,
   input  logic              ot_pin_sel,
   input  logic [NCFG-1:0]   sense_off,
   input  logic [NCH-1:0]    raw_ovl,
   input  logic [NCH-1:0]    raw_ot,
   input  logic [NCH-1:0]    raw_ol,
   input  logic [NCH-1:0]    raw_byp,
   input  logic              ic_hot,
   input  logic              diag_clr,
   output logic [NCH-1:0]    drv_on,
   output logic [NCH-1:0]    diag_pin,
   output logic [2*NCH-1:0]  diag_code,
   output logic              chan_ot,
   output logic              fault_n
);
   import cgd_pkg::*;
   localparam int CFG_BASE = NCH - NCFG;

   logic [NCH-1:0] req, cmd, rise, filt, on_f, off_f, sense_en, otf;
   logic [NCH-1:0] pin_base;

   generate
      if (NCH < 1 || NCFG < 1 || NCFG > NCH) begin : g_bad_cfg
         $error("chan_guard_diag: need 1 <= NCFG <= NCH");
      end

      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dcode_t rcode;
         dcode_t code_i;

         cgd_gate i_gate (
            .clk(clk), .rst_n(rst_n), .par(par_in[i]), .spi(spi_on[i]),
            .and_sel(and_sel), .gate_en(gate_en), .latch_sel(latch_sel),
            .raw_ot(raw_ot[i]), .req(req[i]), .cmd(cmd[i]), .rise(rise[i]),
            .drv_on(drv_on[i])
         );

         if (i >= CFG_BASE) begin : g_cfg_sense
            assign sense_en[i] = ~sense_off[i-CFG_BASE];
         end else begin : g_fixed_sense
            assign sense_en[i] = 1'b1;
         end

         always_comb begin
            on_f[i]  = cmd[i] & (raw_ovl[i] | raw_ot[i]);
            off_f[i] = ~cmd[i] & sense_en[i] & (raw_ol[i] | raw_byp[i]);
            if (on_f[i]) rcode = DC_ONSTATE;
            else if (raw_byp[i]) rcode = DC_BYPASS;
            else rcode = DC_OPEN;
            pin_base[i] = filt[i] ? ~req[i] : req[i];
         end

         cgd_filter #(.FILT_TICKS(FILT_TICKS)) i_filt (
            .clk(clk), .rst_n(rst_n), .tick(tick_us), .clr(diag_clr),
            .raw_any(on_f[i] | off_f[i]), .rcode(rcode),
            .filt(filt[i]), .code(code_i)
         );
         assign diag_code[2*i +: 2] = code_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) otf[i] <= 1'b0;
            else otf[i] <= (otf[i] & ~rise[i]) | (filt[i] & on_f[i] & raw_ot[i]);
         end

         if (i == NCH - 1) begin : g_last_pin
            assign diag_pin[i] = ot_pin_sel ? ~(chan_ot | ic_hot) : pin_base[i];
         end else begin : g_plain_pin
            assign diag_pin[i] = pin_base[i];
         end
      end
   endgenerate

   assign chan_ot = |otf;
   assign fault_n = &diag_code;

   // R2: global disable blanks every drive
   p_disable_blanks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |-> (drv_on == '0));

   // R8: the fault flag only falls after a filtered fault
   p_fault_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> $past(|filt));

   // R10: a channel flag never appears without a filtered fault
   p_otflag_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_ot) |-> $past(|(filt & on_f)));
endmodule

// File: tb/test_chan_guard_diag.sv
module test_chan_guard_diag;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;
   localparam int NCFG = 3;
   localparam int FILT = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0, gate_en = 1'b1, and_sel = 1'b0, latch_sel = 1'b0;
   logic ot_pin_sel = 1'b0, ic_hot = 1'b0, diag_clr = 1'b0;
   logic [NCH-1:0] par_in = '0, spi_on = '0, raw_ovl = '0, raw_ot = '0, raw_ol = '0, raw_byp = '0;
   logic [NCFG-1:0] sense_off = '0;
   logic [NCH-1:0] drv_on, diag_pin;
   logic [2*NCH-1:0] diag_code;
   logic chan_ot, fault_n;

   int n_checks = 0, n_fail = 0;
   string cur_req = "R2";
   int tcnt = 0;

   chan_guard_diag #(.NCH(NCH), .NCFG(NCFG), .FILT_TICKS(FILT)) i_chan_guard_diag (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .gate_en(gate_en),
      .par_in(par_in), .spi_on(spi_on), .and_sel(and_sel), .latch_sel(latch_sel),
      .ot_pin_sel(ot_pin_sel), .sense_off(sense_off), .raw_ovl(raw_ovl),
      .raw_ot(raw_ot), .raw_ol(raw_ol), .raw_byp(raw_byp), .ic_hot(ic_hot),
      .diag_clr(diag_clr), .drv_on(drv_on), .diag_pin(diag_pin),
      .diag_code(diag_code), .chan_ot(chan_ot), .fault_n(fault_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   int   m_cnt [NCH];
   bit [1:0] m_kind [NCH];
   bit [1:0] m_code [NCH];
   bit   m_reqq [NCH], m_lock [NCH], m_otf [NCH];
   // reference model combinational view
   bit   c_req [NCH], c_cmd [NCH], c_drv [NCH], c_onf [NCH], c_any [NCH], c_filt [NCH];
   bit [1:0] c_rcode [NCH];

   function automatic void model_reset();
      for (int i = 0; i < NCH; i++) begin
         m_cnt[i] = 0; m_kind[i] = 2'b11; m_code[i] = 2'b11;
         m_reqq[i] = 0; m_lock[i] = 0; m_otf[i] = 0;
      end
   endfunction

   function automatic void model_comb();
      for (int i = 0; i < NCH; i++) begin
         bit sens, offf;
         c_req[i] = and_sel ? (par_in[i] && spi_on[i]) : (par_in[i] || spi_on[i]);
         c_cmd[i] = c_req[i] && gate_en;
         c_drv[i] = rst_n && c_cmd[i] && !raw_ot[i] && !m_lock[i];
         sens = (i >= NCH - NCFG) ? !sense_off[i-(NCH-NCFG)] : 1'b1;
         c_onf[i] = c_cmd[i] && (raw_ovl[i] || raw_ot[i]);
         offf = !c_cmd[i] && sens && (raw_ol[i] || raw_byp[i]);
         c_any[i] = c_onf[i] || offf;
         c_rcode[i] = c_onf[i] ? 2'b10 : (raw_byp[i] ? 2'b00 : 2'b01);
         c_filt[i] = c_any[i] && (c_rcode[i] == m_kind[i]) && (m_cnt[i] == FILT);
      end
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         model_comb();
         for (int i = 0; i < NCH; i++) begin
            bit rise, same;
            rise = c_req[i] && !m_reqq[i];
            same = c_any[i] && (c_rcode[i] == m_kind[i]);
            m_lock[i] = latch_sel && ((m_lock[i] && !rise) || (c_cmd[i] && raw_ot[i]));
            m_otf[i] = (m_otf[i] && !rise) || (c_filt[i] && c_onf[i] && raw_ot[i]);
            if (diag_clr) m_code[i] = 2'b11;
            else if (c_filt[i]) m_code[i] = c_rcode[i];
            if (diag_clr || !same) m_cnt[i] = 0;
            else if (tick_us && m_cnt[i] != FILT) m_cnt[i]++;
            m_kind[i] = c_rcode[i];
            m_reqq[i] = c_req[i];
         end
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      #2;
      model_comb();
      begin
         logic [NCH-1:0] e_drv, e_pin;
         logic [2*NCH-1:0] e_code;
         bit any_otf;
         any_otf = 0;
         for (int i = 0; i < NCH; i++) any_otf |= m_otf[i];
         for (int i = 0; i < NCH; i++) begin
            e_drv[i] = c_drv[i];
            e_pin[i] = c_filt[i] ? !c_req[i] : c_req[i];
            e_code[2*i +: 2] = m_code[i];
         end
         if (ot_pin_sel) e_pin[NCH-1] = !(any_otf || ic_hot);
         chk("drv_on (R1/R3/R4)", 32'(drv_on), 32'(e_drv));
         chk("diag_pin (R9)", 32'(diag_pin), 32'(e_pin));
         chk("diag_code (R6)", 32'(diag_code), 32'(e_code));
         chk("fault_n (R8)", 32'(fault_n), 32'(&e_code));
         chk("chan_ot (R10)", 32'(chan_ot), 32'(any_otf));
      end
   end

   always @(negedge clk) begin
      tcnt++;
      tick_us = (tcnt % 4 == 0);
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      step(4);
      cur_req = "R2";
      chk("reset code R2", 32'(diag_code), 32'hFFF);
      chk("reset drive R2", 32'(drv_on), 32'h0);
      rst_n = 1'b1;
      step(2);
      // R1: combine patterns in both modes
      cur_req = "R1";
      for (int k = 0; k < 16; k++) begin
         and_sel = k[0];
         par_in = 6'(k * 11);
         spi_on = 6'(k * 7 + 5);
         step(3);
      end
      // R2: global disable
      cur_req = "R2";
      and_sel = 0; par_in = 6'h3F;
      gate_en = 0; step(4);
      chk("disabled R2", 32'(drv_on), 32'h0);
      gate_en = 1; step(2);
      par_in = 0; spi_on = 0; step(2);
      // R3: auto restart
      cur_req = "R3";
      par_in = 6'h01; step(3);
      raw_ot[0] = 1; step(5);
      raw_ot[0] = 0; step(5);
      chk("restart R3", 32'(drv_on[0]), 32'h1);
      // R4: latching
      cur_req = "R4";
      latch_sel = 1; par_in = 6'h02; step(3);
      raw_ot[1] = 1; step(3);
      raw_ot[1] = 0; step(6);
      chk("latched off R4", 32'(drv_on[1]), 32'h0);
      par_in = 0; step(2);
      par_in = 6'h02; step(4);
      chk("released R4", 32'(drv_on[1]), 32'h1);
      latch_sel = 0; step(2);
      // R5 and R9: short fault ignored, long fault filtered
      cur_req = "R5";
      par_in = 6'h04; step(2);
      raw_ovl[2] = 1; step(200);
      raw_ovl[2] = 0; step(5);
      chk("short fault R5", 32'(diag_code[5:4]), 32'h3);
      cur_req = "R9";
      raw_ovl[2] = 1; step(450);
      chk("inverted pin R9", 32'(diag_pin[2]), 32'h0);
      raw_ovl[2] = 0; step(5);
      chk("pin follows R9", 32'(diag_pin[2]), 32'h1);
      par_in = 0; step(2);
      // R6: off-state codes and overwrite
      cur_req = "R6";
      raw_ol[3] = 1; step(450);
      chk("open code R6", 32'(diag_code[7:6]), 32'h1);
      raw_byp[3] = 1; step(450);
      chk("bypass code R6", 32'(diag_code[7:6]), 32'h0);
      raw_ol[3] = 0; raw_byp[3] = 0; step(3);
      // R7 and R8: clear
      cur_req = "R7";
      diag_clr = 1; step(1); diag_clr = 0; step(3);
      chk("cleared R7", 32'(diag_code), 32'hFFF);
      cur_req = "R8";
      chk("flag high R8", 32'(fault_n), 32'h1);
      // R11: masked detection on a configurable channel
      cur_req = "R11";
      sense_off = 3'b001;
      raw_ol[3] = 1; step(450);
      chk("masked R11", 32'(diag_code[7:6]), 32'h3);
      raw_ol[3] = 0; step(2);
      sense_off = 0; step(2);
      // R10: channel overtemperature flag and shared pin
      cur_req = "R10";
      ot_pin_sel = 1; par_in = 6'h01; step(3);
      raw_ot[0] = 1; step(450);
      chk("flag set R10", 32'(chan_ot), 32'h1);
      raw_ot[0] = 0; step(5);
      cur_req = "R7";
      diag_clr = 1; step(1); diag_clr = 0; step(3);
      chk("flag kept R7", 32'(chan_ot), 32'h1);
      cur_req = "R10";
      ic_hot = 1; step(3);
      ic_hot = 0; step(2);
      par_in = 0; step(2);
      par_in = 6'h01; step(3);
      chk("flag cleared R10", 32'(chan_ot), 32'h0);
      // R2: mid-run reset after a latched fault
      cur_req = "R2";
      par_in = 0;
      raw_ol[4] = 1; step(450);
      raw_ol[4] = 0;
      rst_n = 0; step(3);
      chk("reset clears R2", 32'(diag_code), 32'hFFF);
      rst_n = 1; step(5);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule